// File: doc/BRIEF.md
# Exception Return Status Unwinder

This block updates the condition and status word of a processor core when a return-from-exception or a return-from-NMI instruction retires. The status word keeps a small stack of mode fields. Each nested exception pushes a 10-bit level upward, and a return pops one level back down. The two top bits of the word are kept through the pop. The block then sets the pending flag and the NMI-mask flag as the kind of return requires.

When the popped status shows that the core returns to user mode, the block saves the current stack pointer as the kernel stack pointer and loads the stack pointer from the user stack pointer input. The pipeline drives the current status word, the current stack pointer, the user stack pointer and the kind of return together with a one-cycle return strobe. The updated status, the new stack pointer and the saved kernel stack pointer are registered. They change only on the clock edge that samples the strobe.

Top module: `exc_return_unwinder`

## Requirements
- R1: On a return strobe, bits [31:30] of the new status equal bits [31:30] of the input status.
- R2: On a return strobe, new status bits [17:0] take input status bits [27:10], except that bits 7 and 9 may be forced as R3 and R4 state. Input bits [29:28] are dropped, and new bits [29:18] are zero.
- R3: The P flag (bit 7) of the new status is set when the R flag (bit 8) of the input status is 0. When R is 1, P keeps the popped value, which is input bit 17.
- R4: When ret_kind is 1 (NMI return), the M flag (bit 9) of the new status is set. When ret_kind is 0 (exception return), M keeps the popped value, which is input bit 19.
- R5: When the U flag (bit 6) of the popped status is 1, which is input status bit 16, stack_ptr_out takes usr_sp_in and kern_sp_out takes stack_ptr_in.
- R6: When the popped U flag is 0, stack_ptr_out takes stack_ptr_in and kern_sp_out keeps its previous value.
- R7: In a cycle without the return strobe, all three outputs hold their values, whatever the other inputs do.
- R8: Synchronous active-high reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Return strobe, one cycle per retiring return |
| ret_kind | input | 1 | 0 = exception return, 1 = NMI return |
| status_in | input | 32 | Current status word |
| stack_ptr_in | input | 32 | Current stack pointer |
| usr_sp_in | input | 32 | User stack pointer |
| status_out | output | 32 | Status word after the return |
| stack_ptr_out | output | 32 | Stack pointer after the return |
| kern_sp_out | output | 32 | Saved kernel stack pointer |

## Verification
Two actions can fall in the same cycle: the flag forcing (P from a clear R flag, M on an NMI return) and the user-mode stack swap. The bench provokes this with an NMI return whose input status has R clear and bit 16 set. It expects P, M and the popped U all set in status_out, and it expects both stack pointers to be swapped on the same edge. The scoreboard also runs a stream of mixed strobed and idle cycles, so that a swap and the next hold meet on back-to-back cycles.

// File: rtl/unwind_pkg.sv
package unwind_pkg;

    localparam int DATA_W = 32;

    typedef enum logic {
        RET_EXC = 1'b0,
        RET_NMI = 1'b1
    } ret_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] ksp;
    } unw_state_t;

    // Pop one stacked level: keep the top keep_w bits, drop the drop_w
    // bits under them, shift the remaining field down by lvl.
    function automatic logic [DATA_W-1:0] pop_level(
        input logic [DATA_W-1:0] s,
        input int keep_w,
        input int drop_w,
        input int lvl
    );
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= DATA_W - keep_w) begin
                r[i] = s[i];
            end else if (i + lvl < DATA_W - keep_w - drop_w) begin
                r[i] = s[i + lvl];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/unw_status_pop.sv
module unw_status_pop
    import unwind_pkg::*;
#(
    parameter int KEEP_W  = 2,
    parameter int DROP_W  = 2,
    parameter int LEVEL_W = 10,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input  logic [DATA_W-1:0] stat_old,
    input  ret_kind_e         kind,
    output logic [DATA_W-1:0] stat_new
);

    logic [DATA_W-1:0] popped;

    always_comb begin
        popped   = pop_level(stat_old, KEEP_W, DROP_W, LEVEL_W);
        stat_new = popped;
        if (!stat_old[R_POS]) begin
            stat_new[P_POS] = 1'b1;
        end
        if (kind == RET_NMI) begin
            stat_new[M_POS] = 1'b1;
        end
    end

endmodule

// File: rtl/unw_stack_swap.sv
module unw_stack_swap
    import unwind_pkg::*;
#(
    parameter int U_POS = 6
) (
    input  logic [DATA_W-1:0] stat_new,
    input  logic [DATA_W-1:0] sp_cur,
    input  logic [DATA_W-1:0] usp,
    input  logic [DATA_W-1:0] ksp_prev,
    output logic [DATA_W-1:0] sp_next,
    output logic [DATA_W-1:0] ksp_next
);

    always_comb begin
        if (stat_new[U_POS]) begin
            sp_next  = usp;
            ksp_next = sp_cur;
        end else begin
            sp_next  = sp_cur;
            ksp_next = ksp_prev;
        end
    end

endmodule

// File: rtl/unw_state_regs.sv
module unw_state_regs
    import unwind_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  unw_state_t d,
    output unw_state_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/exc_return_unwinder.sv
module exc_return_unwinder
    import unwind_pkg::*;
#(
    parameter int KEEP_W  = 2,
    parameter int DROP_W  = 2,
    parameter int LEVEL_W = 10,
    parameter int C_POS   = 0,
    parameter int V_POS   = 1,
    parameter int Z_POS   = 2,
    parameter int N_POS   = 3,
    parameter int X_POS   = 4,
    parameter int I_POS   = 5,
    parameter int U_POS   = 6,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic              ret_kind,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] stack_ptr_in,
    input  logic [DATA_W-1:0] usr_sp_in,
    output logic [DATA_W-1:0] status_out,
    output logic [DATA_W-1:0] stack_ptr_out,
    output logic [DATA_W-1:0] kern_sp_out
);

    ret_kind_e          kind;
    logic [DATA_W-1:0]  stat_new;
    unw_state_t         next_st;
    unw_state_t         cur_st;

    assign kind = ret_kind_e'(ret_kind);

    unw_status_pop #(
        .KEEP_W (KEEP_W),
        .DROP_W (DROP_W),
        .LEVEL_W(LEVEL_W),
        .P_POS  (P_POS),
        .R_POS  (R_POS),
        .M_POS  (M_POS)
    ) u_pop (
        .stat_old(status_in),
        .kind    (kind),
        .stat_new(stat_new)
    );

    unw_stack_swap #(
        .U_POS(U_POS)
    ) u_swap (
        .stat_new(stat_new),
        .sp_cur  (stack_ptr_in),
        .usp     (usr_sp_in),
        .ksp_prev(cur_st.ksp),
        .sp_next (next_st.sp),
        .ksp_next(next_st.ksp)
    );

    assign next_st.status = stat_new;

    unw_state_regs u_regs (
        .clk (clk),
        .rst (rst),
        .load(ret_valid),
        .d   (next_st),
        .q   (cur_st)
    );

    assign status_out    = cur_st.status;
    assign stack_ptr_out = cur_st.sp;
    assign kern_sp_out   = cur_st.ksp;

endmodule

// File: rtl/unw_checker.sv
module unw_checker
    import unwind_pkg::*;
#(
    parameter int KEEP_W  = 2,
    parameter int DROP_W  = 2,
    parameter int LEVEL_W = 10,
    parameter int U_POS   = 6,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              ret_valid,
    input logic              ret_kind,
    input logic [DATA_W-1:0] status_in,
    input logic [DATA_W-1:0] stack_ptr_in,
    input logic [DATA_W-1:0] usr_sp_in,
    input logic [DATA_W-1:0] status_out,
    input logic [DATA_W-1:0] stack_ptr_out,
    input logic [DATA_W-1:0] kern_sp_out
);

    localparam int U_OLD  = U_POS + LEVEL_W;
    localparam int ZLO    = DATA_W - KEEP_W - DROP_W - LEVEL_W;
    localparam logic [DATA_W-1:0] ZMASK =
        ((DATA_W'(1) << (DROP_W + LEVEL_W)) - DATA_W'(1)) << ZLO;
    localparam logic [DATA_W-1:0] TOPMASK =
        ~((DATA_W'(1) << (DATA_W - KEEP_W)) - DATA_W'(1));

    p_keep_top_r1: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> ((status_out & TOPMASK) == ($past(status_in) & TOPMASK)));

    p_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> ((status_out & ZMASK) == '0));

    p_pend_set_r3: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !status_in[R_POS]) |=> status_out[P_POS]);

    p_nmi_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_kind) |=> status_out[M_POS]);

    p_user_swap_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && status_in[U_OLD]) |=>
            (stack_ptr_out == $past(usr_sp_in)) && (kern_sp_out == $past(stack_ptr_in)));

    p_kernel_stay_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !status_in[U_OLD]) |=>
            (stack_ptr_out == $past(stack_ptr_in)) && $stable(kern_sp_out));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ret_valid |=> ($stable(status_out) && $stable(stack_ptr_out) && $stable(kern_sp_out)));

endmodule

bind exc_return_unwinder unw_checker #(
    .KEEP_W (KEEP_W),
    .DROP_W (DROP_W),
    .LEVEL_W(LEVEL_W),
    .U_POS  (U_POS),
    .P_POS  (P_POS),
    .R_POS  (R_POS),
    .M_POS  (M_POS)
) u_unw_checker (
    .clk          (clk),
    .rst          (rst),
    .ret_valid    (ret_valid),
    .ret_kind     (ret_kind),
    .status_in    (status_in),
    .stack_ptr_in (stack_ptr_in),
    .usr_sp_in    (usr_sp_in),
    .status_out   (status_out),
    .stack_ptr_out(stack_ptr_out),
    .kern_sp_out  (kern_sp_out)
);

// File: tb/tb_exc_return_unwinder.sv
`timescale 1ns/1ps
module tb_exc_return_unwinder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_valid = 1'b0;
    logic        ret_kind = 1'b0;
    logic [31:0] status_in = '0;
    logic [31:0] stack_ptr_in = '0;
    logic [31:0] usr_sp_in = '0;
    logic [31:0] status_out;
    logic [31:0] stack_ptr_out;
    logic [31:0] kern_sp_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] st;
        logic [31:0] sp;
        logic [31:0] ksp;
        string       tag;
    } exp_t;

    exp_t sb[$];

    logic [31:0] m_st = '0;
    logic [31:0] m_sp = '0;
    logic [31:0] m_ksp = '0;

    always #2 clk = ~clk;

    exc_return_unwinder dut (
        .clk          (clk),
        .rst          (rst),
        .ret_valid    (ret_valid),
        .ret_kind     (ret_kind),
        .status_in    (status_in),
        .stack_ptr_in (stack_ptr_in),
        .usr_sp_in    (usr_sp_in),
        .status_out   (status_out),
        .stack_ptr_out(stack_ptr_out),
        .kern_sp_out  (kern_sp_out)
    );

    // Reference model written from the requirements
    task automatic model(input logic k, input logic [31:0] s,
                         input logic [31:0] sp, input logic [31:0] usp);
        logic [31:0] n;
        n = {s[31:30], 12'h000, s[27:10]};
        if (!s[8]) n[7] = 1'b1;
        if (k) n[9] = 1'b1;
        m_st = n;
        if (n[6]) begin
            m_ksp = sp;
            m_sp  = usp;
        end else begin
            m_sp = sp;
        end
    endtask

    task automatic step(input logic v, input logic k, input logic [31:0] s,
                        input logic [31:0] sp, input logic [31:0] usp,
                        input string tag);
        exp_t e;
        @(negedge clk);
        ret_valid    = v;
        ret_kind     = k;
        status_in    = s;
        stack_ptr_in = sp;
        usr_sp_in    = usp;
        if (v) model(k, s, sp, usp);
        e.st = m_st; e.sp = m_sp; e.ksp = m_ksp; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one expected item per edge after it is pushed
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (status_out !== e.st || stack_ptr_out !== e.sp || kern_sp_out !== e.ksp) begin
                    failures++;
                    $display("FAIL %s: got st=%h sp=%h ksp=%h expected st=%h sp=%h ksp=%h",
                             e.tag, status_out, stack_ptr_out, kern_sp_out, e.st, e.sp, e.ksp);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (status_out !== 32'h0 || stack_ptr_out !== 32'h0 || kern_sp_out !== 32'h0) begin
            failures++;
            $display("FAIL R8 reset: got %h %h %h expected 0 0 0",
                     status_out, stack_ptr_out, kern_sp_out);
        end
        rst = 1'b0;

        // R1, R3: top bits kept, P set from clear R, kernel return
        step(1'b1, 1'b0, 32'hC000_0000, 32'h0000_1000, 32'h0000_2000, "R1 R3 R6 top kept, P set");
        // R2, R5: dropped bits, full field pop, user swap
        step(1'b1, 1'b0, 32'h3FFF_FC00, 32'h0000_3000, 32'h0000_4000, "R2 R5 pop and swap");
        // R4: NMI with R set, P not forced
        step(1'b1, 1'b1, 32'h0000_0100, 32'h0000_5000, 32'h0000_6000, "R4 R3 NMI sets M, R set keeps P");
        // R4: exception return keeps popped M, no P
        step(1'b1, 1'b0, 32'h0008_0100, 32'h0000_7000, 32'h0000_8000, "R4 exception keeps popped M");
        // R3: R set, popped P from bit 17
        step(1'b1, 1'b0, 32'h0002_0100, 32'h0000_7100, 32'h0000_8100, "R3 popped P with R set");
        // Same cycle: NMI, R clear, U set -> P, M, U and swap
        step(1'b1, 1'b1, 32'h0001_0000, 32'hAAAA_0000, 32'h5555_0000, "R3 R4 R5 flags with swap");
        // R7: idle with changing inputs
        step(1'b0, 1'b1, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222, "R7 hold idle 1");
        step(1'b0, 1'b0, 32'h0001_0000, 32'h3333_3333, 32'h4444_4444, "R7 hold idle 2");
        // R6: U clear, kernel SP kept from the earlier swap
        step(1'b1, 1'b0, 32'h4000_0000, 32'h0000_9000, 32'h0000_A000, "R6 kernel SP kept");
        // back-to-back swap then hold
        step(1'b1, 1'b0, 32'h0001_0100, 32'h0000_B000, 32'h0000_C000, "R5 swap back-to-back");
        step(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, "R7 hold after swap");

        for (int i = 0; i < 60; i++) begin
            logic [31:0] s;
            s = $urandom;
            step(($urandom % 4) != 0, 1'($urandom % 2), s, $urandom, $urandom, "R2 mixed stream");
        end

        step(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, "R7 final hold");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule